// File: doc/BRIEF.md
# SPI Mode Fault Detector

This block watches the select and clock pins of an SPI port that can run as either bus master or bus slave, and raises a sticky fault flag when the port's role and the pins disagree. As a master with fault detection enabled, any low level on its own select input means another master is driving the bus. The block then tells the surrounding port to drop its enable, to mark the transmit buffer empty and to reset its bit counter. Pin direction control goes back to the general-purpose I/O logic.

As a slave, a fault is a deselect that arrives while a transfer is still in progress. Whether a transfer is in progress depends on the clock phase. With phase 0, pulling select low already starts a transfer, so a select with no clocks followed by a deselect is a fault. With phase 1, a transfer only starts on the first clock edge away from idle, so the same select and deselect is harmless. A slave fault leaves the port enabled. While deselected, a slave releases its data output and passes on no clock edges.

The flag clears only through a two-step sequence: first a status read that observes the flag set, then a control write. Both steps must happen with no fault condition present. A fault between the two steps cancels the sequence. The asynchronous pins pass through two-flop synchronizers. The clock idle level follows the polarity bit.

Top module: `spi_mf_unit`

## Requirements
- R1: With enable=1, master=1 and fault-enable=1, a low synchronized select sets `fault_flag_o`. With fault-enable=0, a low select in master mode leaves the flag at 0.
- R2: A master fault produces exactly one single-cycle pulse on each of `en_clr_o`, `txe_set_o` and `cnt_rst_o`, however long the condition lasts. `pins_gpio_o` is 1 exactly when `cfg_en_i` is 0.
- R3: `err_irq_o` is 1 exactly when `fault_flag_o` is 1 and `cfg_errie_i` is 1.
- R4: In slave mode with phase 0, a falling select starts a transfer. A deselect with fewer than 8 clock edges away from idle (including none) sets the flag.
- R5: In slave mode with phase 1, a select and deselect with no clock edges leaves the flag at 0. A deselect after 1 to 7 edges away from idle sets it.
- R6: In slave mode, for either phase and either polarity, a deselect after 8 edges away from idle and the return to idle that follows each of them leaves the flag at 0. The idle level equals `cfg_cpol_i`.
- R7: A slave fault never pulses `en_clr_o`, `txe_set_o` or `cnt_rst_o`.
- R8: In slave mode, `miso_oe_o` is 1 only while select is low. Edges of the serial clock while select is high give no pulse on `slv_lead_o` or `slv_trail_o`. Each edge away from idle while select is low gives exactly one `slv_lead_o` pulse.
- R9: The flag stays set until a `stat_rd_i` cycle that sees it set is followed, in a later cycle, by a `ctl_wr_i` cycle. A write without a prior read leaves the flag set.
- R10: A clear sequence fails while a fault condition is present. A new fault between the read and the write cancels the pending clear, so a later write alone leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_pin_i | input | 1 | Slave-select pin, asynchronous, active low |
| sck_pin_i | input | 1 | Serial clock pin, asynchronous |
| cfg_en_i | input | 1 | Port enable bit |
| cfg_msel_i | input | 1 | 1 = master role, 0 = slave role |
| cfg_mfen_i | input | 1 | Master fault detection enable |
| cfg_errie_i | input | 1 | Error interrupt enable |
| cfg_cpol_i | input | 1 | Clock polarity; idle level of the serial clock |
| cfg_cpha_i | input | 1 | Clock phase (0 or 1) |
| stat_rd_i | input | 1 | One-cycle strobe: status register read |
| ctl_wr_i | input | 1 | One-cycle strobe: control register write |
| fault_flag_o | output | 1 | Sticky mode fault flag |
| err_irq_o | output | 1 | Receive/error interrupt request |
| en_clr_o | output | 1 | Pulse: clear the port enable bit |
| txe_set_o | output | 1 | Pulse: set the transmit-empty flag |
| cnt_rst_o | output | 1 | Pulse: reset the transfer state counter |
| pins_gpio_o | output | 1 | 1 = general-purpose I/O logic owns pin direction |
| miso_oe_o | output | 1 | Slave data output enable |
| slv_lead_o | output | 1 | Qualified slave clock edge away from idle |
| slv_trail_o | output | 1 | Qualified slave clock edge back to idle |

## Verification
A wrong transfer-tracking state appears at the flag only at the next deselect. A tracker that misses an edge or ends early either raises a fault after a complete 8-edge transfer or misses one after a partial transfer. For this reason the bench sweeps edge counts 0 to 8 over all four polarity and phase settings, and checks the flag a few cycles after each deselect. A wrong clear-sequence state shows one write later: the flag either stays set after a valid read and write, or falls after a write with no read or after a cancelled read. Pulse outputs that repeat or come from a slave fault are caught by counting pulses over each whole scenario.

// File: rtl/spi_mf_pkg.sv
// Package: shared configuration record for the mode fault detector.
// Assumes all fields are static register bits in the clock domain.
package spi_mf_pkg;

    typedef struct packed {
        logic en;      // port enable
        logic msel;    // 1 = master role
        logic mfen;    // master fault detection enable
        logic errie;   // error interrupt enable
        logic cpol;    // serial clock idle level
        logic cpha;    // clock phase
    } spi_mf_cfg_t;

endpackage

// File: rtl/spi_mf_sync.sv
// Multi-flop synchronizer for one asynchronous pin.
// Assumes STAGES >= 2; RST_VAL is the pin's inactive level.
module spi_mf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin value through the synchronizing chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_mf_slvtrack.sv
// Slave transfer tracker: decides whether a transfer is in progress and
// reports a slave fault when select rises during one.
// Assumes synchronized pins. Phase 0 starts a transfer on the select fall;
// phase 1 starts it on the first edge away from idle. Both end on the return
// to idle after XFER_BITS edges away from idle.
module spi_mf_slvtrack
    import spi_mf_pkg::*;
#(
    parameter int XFER_BITS = 8,
    localparam int CNT_W    = $clog2(XFER_BITS + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  spi_mf_cfg_t cfg,
    input  logic        ss_s,
    input  logic        sck_s,
    output logic        slv_fault_o,
    output logic        lead_o,
    output logic        trail_o,
    output logic        miso_oe_o
);
    logic             ss_d, sck_d;
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             slave_on, sel, ss_fall, ss_rise, lead, trail;

    assign slave_on = cfg.en & ~cfg.msel;
    assign sel      = slave_on & ~ss_s;
    assign ss_fall  = ss_d & ~ss_s;
    assign ss_rise  = ~ss_d & ss_s;
    assign lead     = sel & (sck_d == cfg.cpol) & (sck_s != cfg.cpol);
    assign trail    = sel & (sck_d != cfg.cpol) & (sck_s == cfg.cpol);

    // Remember the previous synchronized pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            ss_d  <= ss_s;
            sck_d <= sck_s;
        end
    end

    // Track transfer start, edge count and end.
    always_ff @(posedge clk) begin
        if (!rst_n || !slave_on || ss_s) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (!cfg.cpha && ss_fall) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (lead) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(1);
            end
        end else begin
            if (lead && cnt_q != CNT_W'(XFER_BITS))
                cnt_q <= cnt_q + CNT_W'(1);
            if (trail && cnt_q == CNT_W'(XFER_BITS)) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end
        end
    end

    assign slv_fault_o = slave_on & ss_rise & busy_q;
    assign lead_o      = lead;
    assign trail_o     = trail;
    assign miso_oe_o   = sel;
endmodule

// File: rtl/spi_mf_flag.sv
// Sticky fault flag with a two-step clear: a status read that sees the flag
// set arms the clear, and a later control write completes it.
// Assumes one-cycle strobes. Any fault sets the flag and disarms the clear.
module spi_mf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic stat_rd_i,
    input  logic ctl_wr_i,
    output logic flag_o
);
    logic flag_q, armed_q;

    // Set on fault, arm on read, clear on armed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (fault_i) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            if (stat_rd_i && flag_q) armed_q <= 1'b1;
            if (ctl_wr_i && armed_q) begin
                flag_q  <= 1'b0;
                armed_q <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/spi_mf_unit.sv
// Mode fault detection unit for an SPI port. It synchronizes the pins,
// detects master and slave mode faults, holds the sticky flag and drives
// the disable, transmit-empty and counter-reset pulses of a master fault.
// Assumes configuration bits are quasi-static and strobes last one cycle.
module spi_mf_unit
    import spi_mf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int XFER_BITS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_pin_i,
    input  logic sck_pin_i,
    input  logic cfg_en_i,
    input  logic cfg_msel_i,
    input  logic cfg_mfen_i,
    input  logic cfg_errie_i,
    input  logic cfg_cpol_i,
    input  logic cfg_cpha_i,
    input  logic stat_rd_i,
    input  logic ctl_wr_i,
    output logic fault_flag_o,
    output logic err_irq_o,
    output logic en_clr_o,
    output logic txe_set_o,
    output logic cnt_rst_o,
    output logic pins_gpio_o,
    output logic miso_oe_o,
    output logic slv_lead_o,
    output logic slv_trail_o
);
    spi_mf_cfg_t cfg;
    logic ss_s, sck_s;
    logic mst_cond, mst_cond_d, slv_fault, fault_c;
    logic mst_pulse_q;

    assign cfg = '{en: cfg_en_i, msel: cfg_msel_i, mfen: cfg_mfen_i,
                   errie: cfg_errie_i, cpol: cfg_cpol_i, cpha: cfg_cpha_i};

    spi_mf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ss_pin_i), .q_o(ss_s));

    spi_mf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sck_pin_i), .q_o(sck_s));

    spi_mf_slvtrack #(.XFER_BITS(XFER_BITS)) u_track (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .ss_s(ss_s), .sck_s(sck_s),
        .slv_fault_o(slv_fault), .lead_o(slv_lead_o),
        .trail_o(slv_trail_o), .miso_oe_o(miso_oe_o));

    assign mst_cond = cfg.en & cfg.msel & cfg.mfen & ~ss_s;
    assign fault_c  = mst_cond | slv_fault;

    spi_mf_flag u_flag (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_c),
        .stat_rd_i(stat_rd_i), .ctl_wr_i(ctl_wr_i), .flag_o(fault_flag_o));

    // Emit one action pulse at the onset of a master fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_cond_d  <= 1'b0;
            mst_pulse_q <= 1'b0;
        end else begin
            mst_cond_d  <= mst_cond;
            mst_pulse_q <= mst_cond & ~mst_cond_d;
        end
    end

    assign en_clr_o    = mst_pulse_q;
    assign txe_set_o   = mst_pulse_q;
    assign cnt_rst_o   = mst_pulse_q;
    assign pins_gpio_o = ~cfg.en;
    assign err_irq_o   = fault_flag_o & cfg.errie;
endmodule

// File: rtl/spi_mf_checker.sv
// Property checker for the mode fault unit, bound to every instance.
module spi_mf_checker (
    input logic clk,
    input logic rst_n,
    input logic ss_s,
    input logic fault_c,
    input logic cfg_en_i,
    input logic cfg_msel_i,
    input logic cfg_mfen_i,
    input logic cfg_errie_i,
    input logic ctl_wr_i,
    input logic fault_flag_o,
    input logic err_irq_o,
    input logic en_clr_o
);
    a_r1_master_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_i && cfg_msel_i && cfg_mfen_i && !ss_s) |=> fault_flag_o);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_o |=> !en_clr_o);

    a_r7_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_o |-> $past(cfg_msel_i));

    a_r3_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> (fault_flag_o && cfg_errie_i));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag_o && !ctl_wr_i) |=> fault_flag_o);

    a_r10_no_clear_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_flag_o) |-> ($past(ctl_wr_i) && !$past(fault_c)));
endmodule

bind spi_mf_unit spi_mf_checker u_mf_chk (
    .clk(clk), .rst_n(rst_n), .ss_s(ss_s), .fault_c(fault_c),
    .cfg_en_i(cfg_en_i), .cfg_msel_i(cfg_msel_i), .cfg_mfen_i(cfg_mfen_i),
    .cfg_errie_i(cfg_errie_i), .ctl_wr_i(ctl_wr_i),
    .fault_flag_o(fault_flag_o), .err_irq_o(err_irq_o), .en_clr_o(en_clr_o));

// File: tb/test_spi_mf_unit.sv
// Bench for spi_mf_unit: master faults, a sweep of slave edge counts over
// polarity and phase, and the clear sequence.
module test_spi_mf_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ss = 1'b1, sck = 1'b0;
    logic en = 1'b0, msel = 1'b0, mfen = 1'b0, errie = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic rd = 1'b0, wr = 1'b0;
    logic flag, irq, enclr, txe, cntrst, gpio, oe, lead, trail;
    int   n_run = 0, n_fail = 0;
    int   c_enclr = 0, c_txe = 0, c_cnt = 0, c_lead = 0, c_trail = 0;

    always #10 clk = ~clk;

    spi_mf_unit i_spi_mf_unit (
        .clk(clk), .rst_n(rst_n), .ss_pin_i(ss), .sck_pin_i(sck),
        .cfg_en_i(en), .cfg_msel_i(msel), .cfg_mfen_i(mfen),
        .cfg_errie_i(errie), .cfg_cpol_i(cpol), .cfg_cpha_i(cpha),
        .stat_rd_i(rd), .ctl_wr_i(wr), .fault_flag_o(flag),
        .err_irq_o(irq), .en_clr_o(enclr), .txe_set_o(txe),
        .cnt_rst_o(cntrst), .pins_gpio_o(gpio), .miso_oe_o(oe),
        .slv_lead_o(lead), .slv_trail_o(trail));

    // Count output pulses, sampled away from the active edge.
    always @(negedge clk) begin
        if (enclr)  c_enclr++;
        if (txe)    c_txe++;
        if (cntrst) c_cnt++;
        if (lead)   c_lead++;
        if (trail)  c_trail++;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic zero_counts();
        c_enclr = 0; c_txe = 0; c_cnt = 0; c_lead = 0; c_trail = 0;
    endtask

    task automatic do_clear();
        rd = 1'b1; tick(1); rd = 1'b0;
        wr = 1'b1; tick(1); wr = 1'b0;
        tick(1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // Reset state
        chk("R9 reset flag", flag, 0);
        chk("R3 reset irq", irq, 0);
        chk("R2 reset gpio", gpio, 1);

        // Master fault: R1, R2, R3, R7
        en = 1; msel = 1; mfen = 1; errie = 0;
        tick(4);
        chk("R2 gpio when enabled", gpio, 0);
        zero_counts();
        ss = 0; tick(8);
        chk("R1 master flag", flag, 1);
        chk("R2 en_clr pulses", c_enclr, 1);
        chk("R2 txe pulses", c_txe, 1);
        chk("R2 cnt_rst pulses", c_cnt, 1);
        chk("R3 irq masked", irq, 0);
        errie = 1; tick(1);
        chk("R3 irq enabled", irq, 1);
        // R10: clear fails while condition persists
        do_clear();
        chk("R10 clear in fault", flag, 1);
        en = 0; tick(1);
        chk("R2 gpio after disable", gpio, 1);
        ss = 1; tick(4);
        // R9: write with no read
        wr = 1; tick(1); wr = 0; tick(1);
        chk("R9 write only", flag, 1);
        do_clear();
        chk("R9 read then write", flag, 0);
        chk("R3 irq cleared", irq, 0);
        // R1: fault-enable off
        en = 1; mfen = 0; zero_counts();
        ss = 0; tick(8);
        chk("R1 mfen off flag", flag, 0);
        chk("R2 mfen off pulse", c_enclr, 0);
        ss = 1; tick(4);

        // Slave sweep over polarity, phase and edge count
        msel = 0; mfen = 1; errie = 1;
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n <= 8; n++) begin
                int exp_f;
                en = 0; cpol = p[1]; cpha = p[0]; sck = p[1];
                tick(4);
                en = 1; tick(2);
                if (flag) do_clear();
                zero_counts();
                // R8: clocks while deselected are ignored
                for (int k = 0; k < 2; k++) begin
                    sck = ~cpol; tick(3); sck = cpol; tick(3);
                end
                chk("R8 lead ignored", c_lead + c_trail, 0);
                chk("R8 oe deselected", oe, 0);
                ss = 0; tick(4);
                chk("R8 oe selected", oe, 1);
                for (int k = 0; k < n; k++) begin
                    sck = ~cpol; tick(4); sck = cpol; tick(4);
                end
                chk("R8 lead count", c_lead, n);
                ss = 1; tick(5);
                exp_f = (n == 0) ? ((p[0] == 1'b0) ? 1 : 0) : ((n < 8) ? 1 : 0);
                if (n == 0 && p[0] == 1'b0)      chk("R4 phase0 no clocks", flag, exp_f);
                else if (n == 0)                 chk("R5 phase1 no clocks", flag, exp_f);
                else if (n == 8)                 chk("R6 full transfer", flag, exp_f);
                else if (p[0] == 1'b0)           chk("R4 phase0 partial", flag, exp_f);
                else                             chk("R5 phase1 partial", flag, exp_f);
                chk("R3 slave irq", irq, exp_f);
                chk("R7 slave no disable", c_enclr + c_txe + c_cnt, 0);
            end
        end

        // R10: new fault between read and write cancels the clear
        cpha = 0; cpol = 0; sck = 0; tick(4);
        if (!flag) begin ss = 0; tick(4); ss = 1; tick(5); end
        chk("R10 setup flag", flag, 1);
        rd = 1; tick(1); rd = 0;
        ss = 0; tick(4); ss = 1; tick(5);
        wr = 1; tick(1); wr = 0; tick(1);
        chk("R10 cancelled clear", flag, 1);
        wr = 1; tick(1); wr = 0; tick(1);
        chk("R10 write after cancel", flag, 1);
        do_clear();
        chk("R9 full sequence", flag, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule